// File: doc/BRIEF.md
# Mailbox Pointer Register Loader

This block owns a small file of 32-bit pointer registers. It moves a value between one of those registers and a single word in shared external memory, called the mailbox. A host programs the block through three byte-wide registers. The first is a control register, which selects a pointer register, picks a direction and positions an internal byte pointer. The second is a mailbox-address port, which is read and written one byte at a time with the most significant byte first. The third is a status register whose bit 0 is an operation-complete flag.

To run a transfer, the host first points the byte pointer at the top byte and writes the four address bytes. It then writes the control register with the wanted index and direction. Finally it writes the status register with bit 0 clear. Clearing the flag starts the transfer. The block issues one 32-bit access on a valid/ready memory port at the low 28 bits of the mailbox address. When the access completes, the block sets the flag again.

The memory port follows valid/ready rules. `mem_valid` rises one cycle after the start. While `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady. The handshake completes in the first cycle in which both are high. For a load, `mem_rdata` must be valid in that same cycle. After reset the address port reads back a revision code.

Top module: `mbox_ptr_loader`

## Requirements
- R1: After reset the flag (status bit 0) reads 1, `mem_valid` is 0, the byte pointer is 0, the mailbox address holds the revision code `REV_CODE`, and every pointer register holds 0.
- R2: A control-register write stores the index in bits [4:0], the direction in bit 5 and the byte pointer in bits [7:6]. The value 0x00 selects the most significant address byte. A control read returns the same layout.
- R3: Each write to the mailbox-address port stores the byte at the byte pointer and then advances the pointer by one. Pointer 0 is address bits [31:24] and pointer 3 is bits [7:0]. The pointer wraps from 3 to 0.
- R4: Each read of the mailbox-address port returns the byte at the byte pointer and advances the pointer. After reset, four reads return `REV_CODE` most significant byte first.
- R5: `mem_addr` equals bits [27:0] of the loaded mailbox address. Bits [31:28] have no effect.
- R6: A status write with bit 0 = 0 while the flag is 1 starts a transfer. On the next cycle `mem_valid` is 1 and the flag reads 0.
- R7: While `mem_valid` is 1 and `mem_ready` is 0, the signals `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` keep their values.
- R8: With direction 0, the block drives `mem_we` = 0. The `mem_rdata` value seen at the handshake is written into the selected pointer register.
- R9: With direction 1, the block drives `mem_we` = 1 and `mem_wdata` carries the selected pointer register.
- R10: In the cycle after the handshake, `mem_valid` is 0 and the flag reads 1.
- R11: A status write with bit 0 = 1, or any status write while a transfer is in flight, starts nothing. The flag, `mem_valid` and the in-flight access are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe; advances the byte pointer on an address-port read |
| host_sel | input | 2 | Register select: 0 control, 1 mailbox address, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or finishes the request |
| mem_we | output | 1 | 1 = write the mailbox, 0 = read it |
| mem_addr | output | 28 | Mailbox word address |
| mem_wdata | output | 32 | Data written to the mailbox |
| mem_rdata | input | 32 | Mailbox data returned with `mem_ready` |

## Verification
A wrong byte pointer shows up on the very next address-port read, as a byte taken from the wrong lane of the revision code or of the loaded address. It also shows up as a mailbox address with its bytes swapped when the next transfer starts. Pointer-file corruption stays hidden until a dump of that register, so every register is loaded and then dumped, and each word is compared on `mem_wdata`. A broken handshake is visible within one cycle: `mem_valid` either drops too early or stays high after `mem_ready`, and the flag is misread.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
  localparam int HOST_W = 8;
  localparam int WORD_W = 32;
  localparam int MADDR_W = 28;
  localparam int BYTES = WORD_W / HOST_W;
  localparam int BP_W = $clog2(BYTES);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MBOX = 2'd1,
    SEL_STAT = 2'd2
  } host_sel_e;
endpackage

// File: rtl/mpl_mbox_addr.sv
module mpl_mbox_addr
  import mpl_pkg::*;
#(
  parameter logic [WORD_W-1:0] REV_CODE = 32'h5A3C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_load,
  input  logic [BP_W-1:0]   bp_value,
  input  logic              byte_wr,
  input  logic              byte_rd,
  input  logic [HOST_W-1:0] byte_in,
  output logic [BP_W-1:0]   bp,
  output logic [HOST_W-1:0] byte_out,
  output logic [WORD_W-1:0] mbox_word
);
  logic [HOST_W-1:0] lane [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) bp <= '0;
    else if (bp_load) bp <= bp_value;
    else if (byte_wr || byte_rd) bp <= bp + 1'b1;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam int HI = WORD_W - 1 - g * HOST_W;
    always_ff @(posedge clk) begin
      if (!rst_n) lane[g] <= REV_CODE[HI -: HOST_W];
      else if (byte_wr && bp == BP_W'(g)) lane[g] <= byte_in;
    end
    assign mbox_word[HI -: HOST_W] = lane[g];
  end

  assign byte_out = lane[bp];

  p_lane_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !bp_load) |=> (lane[$past(bp)] == $past(byte_in)));
endmodule

// File: rtl/mpl_ptr_file.sv
module mpl_ptr_file
  import mpl_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (we && idx == IDX_W'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = regs[idx];

  p_reg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/mpl_xfer_ctl.sv
module mpl_xfer_ctl
  import mpl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_in,
  input  logic [IDX_W-1:0]   idx_in,
  input  logic [WORD_W-1:0]  mbox_word,
  output logic               busy,
  output logic [IDX_W-1:0]   idx_q,
  output logic               ram_we,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr
);
  logic dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_q    <= 1'b0;
      idx_q    <= '0;
      mem_addr <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        dir_q    <= dir_in;
        idx_q    <= idx_in;
        mem_addr <= mbox_word[MADDR_W-1:0];
      end
    end else if (mem_ready) begin
      busy <= 1'b0;
    end
  end

  assign mem_valid = busy;
  assign mem_we    = dir_q;
  assign ram_we    = busy && mem_ready && !dir_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(idx_q)));
  p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);
endmodule

// File: rtl/mbox_ptr_loader.sv
module mbox_ptr_loader
  import mpl_pkg::*;
#(
  parameter logic [31:0] REV_CODE = 32'h5A3C_0001,
  parameter int NREGS = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [1:0]   host_sel,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic         mem_we,
  output logic [27:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [31:0]  mem_rdata
);
  logic              ctrl_wr, mbox_wr, mbox_rd, stat_wr, start, busy, done, ram_we;
  logic              dir_r;
  logic [IDX_W-1:0]  idx_r, idx_q;
  logic [BP_W-1:0]   bp;
  logic [HOST_W-1:0] mbox_byte;
  logic [WORD_W-1:0] mbox_word;

  assign ctrl_wr = host_wr && host_sel == SEL_CTRL;
  assign mbox_wr = host_wr && host_sel == SEL_MBOX;
  assign mbox_rd = host_rd && host_sel == SEL_MBOX;
  assign stat_wr = host_wr && host_sel == SEL_STAT;
  assign done    = !busy;
  assign start   = stat_wr && !host_wdata[0] && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_r <= '0;
      dir_r <= 1'b0;
    end else if (ctrl_wr) begin
      idx_r <= host_wdata[IDX_W-1:0];
      dir_r <= host_wdata[5];
    end
  end

  mpl_mbox_addr #(.REV_CODE(REV_CODE)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .bp_load(ctrl_wr), .bp_value(host_wdata[7:6]),
    .byte_wr(mbox_wr), .byte_rd(mbox_rd), .byte_in(host_wdata),
    .bp(bp), .byte_out(mbox_byte), .mbox_word(mbox_word)
  );

  mpl_xfer_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_r), .idx_in(idx_r),
    .mbox_word(mbox_word), .busy(busy), .idx_q(idx_q), .ram_we(ram_we),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  mpl_ptr_file #(.NREGS(NREGS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(idx_q),
    .wdata(mem_rdata), .rdata(mem_wdata)
  );

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_CTRL: host_rdata = {bp, dir_r, 5'(idx_r)};
      SEL_MBOX: host_rdata = mbox_byte;
      SEL_STAT: host_rdata = {7'd0, done};
      default:  host_rdata = '0;
    endcase
  end

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_valid && host_sel != SEL_STAT || mem_valid));
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && busy && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_wdata));
endmodule

// File: tb/sim_mbox_ptr_loader.sv
module sim_mbox_ptr_loader;
  localparam logic [31:0] REV = 32'h5A3C_0001;

  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [1:0]  host_sel = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        mem_valid, mem_ready = 0, mem_we;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbox_ptr_loader #(.REV_CODE(REV)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hrd(logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1; host_sel = sel;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'h9E37_79B9 * (i + 1);
  endfunction

  // One transfer: program address, control, start, answer after dly cycles.
  task automatic xfer(int idx, bit dir, logic [31:0] a32, int dly, logic [31:0] rd,
                      bit poke, output logic [31:0] wd);
    logic [7:0] s;
    hwr(0, 8'h00);
    for (int b = 0; b < 4; b++) hwr(1, a32[31-8*b -: 8]);
    hwr(0, {2'b00, dir, 5'(idx)});
    hwr(2, 8'h00);
    chk("R6 valid", {31'd0, mem_valid}, 1);
    host_sel = 2; #1 chk("R6 flag", {31'd0, host_rdata[0]}, 0);
    chk("R5 addr", {4'd0, mem_addr}, {4'd0, a32[27:0]});
    chk(dir ? "R9 we" : "R8 we", {31'd0, mem_we}, {31'd0, dir});
    wd = mem_wdata;
    for (int k = 0; k < dly; k++) begin
      if (poke && k == 0) begin host_wr = 1; host_sel = 2; host_wdata = 8'h00; end
      @(negedge clk);
      host_wr = 0;
      chk("R7 valid", {31'd0, mem_valid}, 1);
      chk("R7 addr", {4'd0, mem_addr}, {4'd0, a32[27:0]});
      chk("R7 wdata", mem_wdata, wd);
      if (poke) chk("R11 busy", {31'd0, mem_valid}, 1);
    end
    mem_ready = 1; mem_rdata = rd;
    @(negedge clk);
    mem_ready = 0; mem_rdata = 0;
    chk("R10 valid", {31'd0, mem_valid}, 0);
    host_sel = 2; #1 chk("R10 flag", {31'd0, host_rdata[0]}, 1);
    s = 0;
  endtask

  initial begin
    logic [7:0] d;
    logic [31:0] wd, a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 valid", {31'd0, mem_valid}, 0);
    hrd(2, d); chk("R1 flag", {24'd0, d}, 1);
    hrd(0, d); chk("R1 ctrl", {24'd0, d}, 0);
    // R4 revision readback, R3 wrap
    for (int b = 0; b < 4; b++) begin hrd(1, d); chk("R4 rev byte", {24'd0, d}, {24'd0, REV[31-8*b -: 8]}); end
    hrd(1, d); chk("R3 wrap", {24'd0, d}, {24'd0, REV[31:24]});
    // R1 pointer file starts zero
    xfer(7, 1, 32'h0000_0100, 0, 0, 0, wd); chk("R1 ptr zero", wd, 0);
    // Sweep loads (R8) with high-nibble garbage (R5) and varied back-pressure (R7)
    for (int i = 0; i < 32; i++) begin
      a = 32'hF123_0000 | (i << 4);
      xfer(i, 0, a, i % 4, pat(i), 0, wd);
    end
    // Dump sweep (R9, R8)
    for (int i = 0; i < 32; i++) begin
      a = 32'hA000_8000 | (i << 2);
      xfer(i, 1, a, (i + 1) % 3, 32'hDEAD_BEEF, 0, wd);
      chk("R8 R9 dump", wd, pat(i));
    end
    // R2: byte pointer from control bits [7:6]; mailbox now 32'hA000_807C
    hwr(0, 8'hA3);
    hrd(0, d); chk("R2 ctrl read", {24'd0, d}, 32'hA3);
    hrd(1, d); chk("R2 bp lane", {24'd0, d}, 32'h80);
    hrd(1, d); chk("R3 advance", {24'd0, d}, 32'h7C);
    hwr(0, 8'h00);
    hrd(1, d); chk("R2 msb", {24'd0, d}, 32'hA0);
    // R3: write lanes starting at pointer 2
    hwr(0, 8'h80);
    hwr(1, 8'h11); hwr(1, 8'h22); hwr(1, 8'h33);
    hwr(0, 8'h00);
    for (int b = 0; b < 4; b++) begin
      hrd(1, d);
      chk("R3 lanes", {24'd0, d}, {24'd0, (32'h3300_1122 >> (24 - 8*b)) & 32'hFF});
    end
    // R11: status write with bit0=1 starts nothing
    hwr(2, 8'hFF);
    chk("R11 bit1", {31'd0, mem_valid}, 0);
    @(negedge clk); chk("R11 bit1 later", {31'd0, mem_valid}, 0);
    // R11: restart attempt while busy
    xfer(3, 1, 32'h0000_0040, 2, 0, 1, wd);
    chk("R11 dump intact", wd, pat(3));
    @(negedge clk); chk("R11 no second", {31'd0, mem_valid}, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule